// File: doc/BRIEF.md
# Fuse Array Manual Read Sequencer

This block reads a one-time-programmable fuse macro through its manual read pins, with no processor involved. A requester gives a start address and an item count with a one-cycle request strobe. The block first moves the macro into read mode. For each item it then drives the address, waits, raises the strobe, waits, captures the macro's read data, drops the strobe and waits again. After the last item it leaves the macro in a parked state and pulses a done flag.

The macro pins are grouped into one 32-bit control word. The bit positions of the pins are fixed. The address field sits at a position that is set by a parameter. Three parameters cover the macro variants:

- The entry style selects one of three read-mode entries: plain load, a chip-select-bar cycle followed by load with program-enable-bar, or the wide-word entry.
- The park style selects the state left after the last item: inactive, standby or power-down.
- The capture width is 8 bits for the byte-wide macros and 32 bits for the word-wide macro.

Every wait has the same length, in clock cycles, equal to the clock frequency in MHz times the wait in microseconds.

Top module: `fuse_read_seq`

## Requirements
- R1: After reset the control word equals the park word, and busy, done and result-valid are low.
- R2: Read-mode entry drives these control words. Plain style drives 0x004, held for one wait. Two-step style drives 0x001 for one cycle, then 0x00C held for one wait. Wide style drives 0x28C held for one wait. Bit 0 is chip-select-bar, bit 1 strobe, bit 2 load, bit 3 program-enable-bar, bit 5 power-down, bit 7 sense-buffer enable and bit 9 strobe-select.
- R3: During each item the address occupies ADDR_W bits of the control word starting at bit ADDR_LSB, ORed onto the entry word.
- R4: Each item runs three phases of exactly WAIT_CYC cycles each: address only, address with bit 1 set, and address with bit 1 clear.
- R5: The read data (the low CAP_W bits) is captured on the last cycle of the strobe phase. It is shown on the result output from the first cycle of the following phase, with result-valid high for that one cycle only.
- R6: After the last item the control word becomes the park word: 0x000 for inactive, 0x009 for standby, 0x021 for power-down. Busy falls in the same cycle, and done pulses for one cycle.
- R7: A request that arrives while busy is high has no effect on any output.
- R8: A request with a count of zero pulses done in the next cycle. Busy stays low and the control word is not changed.
- R9: The address goes up by one per item and wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | One-cycle request strobe |
| req_addr | input | ADDR_W | First fuse address |
| req_count | input | CNT_W | Number of items to read |
| fuse_rdata | input | CAP_W | Read data from the macro |
| ctrl_word | output | 32 | Macro pins plus address field |
| busy | output | 1 | High from request accept until the park word is driven |
| res_valid | output | 1 | One-cycle flag for a new captured item |
| res_data | output | CAP_W | Last captured item |
| done | output | 1 | One-cycle end-of-request flag |

## Verification
The assertions assume the following about the inputs:

- Requests are issued only with rst_n high.
- fuse_rdata is a function of the address field and stays steady for the whole time the strobe bit is set.

Under these assumptions the assertions check the following properties:

- The strobe is never raised outside read mode.
- The address does not move while the strobe is up.
- Results and done are one-cycle pulses.

The bench models the macro combinationally from the control word, and returns a fixed junk value whenever the strobe is low. A capture in the wrong cycle therefore shows up in the data. The bench issues each request for exactly one cycle, and injects extra requests in the middle of a busy run only to check that they are ignored.

// File: rtl/fuse_read_seq.sv
module fuse_read_seq #(
  parameter int ADDR_LSB   = 8,
  parameter int ADDR_W     = 8,
  parameter int CAP_W      = 8,
  parameter int CNT_W      = ADDR_W + 1,
  parameter int ENTRY_MODE = 0,
  parameter int PARK_MODE  = 0,
  parameter int CLK_MHZ    = 200,
  parameter int WAIT_US    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [CAP_W-1:0]  fuse_rdata,
  output logic [31:0]       ctrl_word,
  output logic              busy,
  output logic              res_valid,
  output logic [CAP_W-1:0]  res_data,
  output logic              done
);
  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int TW = $clog2(WAIT_CYC + 1);
  localparam logic [TW-1:0] RELOAD = TW'(WAIT_CYC - 1);
  localparam logic [31:0] STRB_BIT = 32'h2;
  localparam logic [31:0] ENTRY_W = (ENTRY_MODE == 2) ? 32'h28C :
                                    (ENTRY_MODE == 1) ? 32'h00C : 32'h004;
  localparam logic [31:0] PARK_W  = (PARK_MODE == 2) ? 32'h021 :
                                    (PARK_MODE == 1) ? 32'h009 : 32'h000;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_ENTER, S_ADDR, S_STRB, S_HOLD} state_t;

  state_t            state;
  logic [TW-1:0]     timer;
  logic [ADDR_W-1:0] cur;
  logic [CNT_W-1:0]  left;
  logic              tz;
  logic [ADDR_W-1:0] addr_field;

  assign tz = (timer == '0);
  assign addr_field = ctrl_word[ADDR_LSB +: ADDR_W];

  function automatic logic [31:0] place(input logic [ADDR_W-1:0] a);
    return ENTRY_W | (32'(a) << ADDR_LSB);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      timer     <= '0;
      cur       <= '0;
      left      <= '0;
      ctrl_word <= PARK_W;
      busy      <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
      done      <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      done      <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          if (req_count == '0) begin
            done <= 1'b1;
          end else begin
            busy  <= 1'b1;
            cur   <= req_addr;
            left  <= req_count;
            timer <= RELOAD;
            if (ENTRY_MODE == 1) begin
              ctrl_word <= 32'h001;
              state     <= S_PRE;
            end else begin
              ctrl_word <= ENTRY_W;
              state     <= S_ENTER;
            end
          end
        end
        S_PRE: begin
          ctrl_word <= ENTRY_W;
          state     <= S_ENTER;
        end
        S_ENTER: begin
          if (tz) begin
            ctrl_word <= place(cur);
            timer     <= RELOAD;
            state     <= S_ADDR;
          end else timer <= timer - 1'b1;
        end
        S_ADDR: begin
          if (tz) begin
            ctrl_word <= ctrl_word | STRB_BIT;
            timer     <= RELOAD;
            state     <= S_STRB;
          end else timer <= timer - 1'b1;
        end
        S_STRB: begin
          if (tz) begin
            res_data  <= fuse_rdata;
            res_valid <= 1'b1;
            ctrl_word <= ctrl_word & ~STRB_BIT;
            timer     <= RELOAD;
            state     <= S_HOLD;
          end else timer <= timer - 1'b1;
        end
        S_HOLD: begin
          if (tz) begin
            if (left == CNT_W'(1)) begin
              ctrl_word <= PARK_W;
              busy      <= 1'b0;
              done      <= 1'b1;
              state     <= S_IDLE;
            end else begin
              cur       <= cur + 1'b1;
              left      <= left - 1'b1;
              ctrl_word <= place(cur + 1'b1);
              timer     <= RELOAD;
              state     <= S_ADDR;
            end
          end else timer <= timer - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_strobe_in_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[1] |-> ctrl_word[2]);

  p_addr_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[1] && $past(ctrl_word[1])) |-> $stable(addr_field));

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_park_on_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && ctrl_word == PARK_W));

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_count == '0) |=> (done && !busy && $stable(ctrl_word)));
endmodule

// File: tb/test_fuse_read_seq.sv
module test_fuse_read_seq;
  localparam int W = 6;
  localparam logic [31:0] ENT_B = 32'h00C, ENT_W = 32'h28C;
  localparam logic [31:0] PARK_B = 32'h009, PARK_W = 32'h021;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] req_v = 2'b00;
  logic [9:0] req_addr = '0;
  logic [10:0] req_count = '0;
  logic [31:0] ctrl_b, ctrl_w, rd_w, data_w;
  logic [7:0] rd_b, data_b;
  logic busy_b, busy_w, rv_b, rv_w, done_b, done_w;
  int checks = 0, fails = 0;
  int kstep = 0, poke_at = 0, poke_sel = 0;
  logic [31:0] exp_d [2];

  always #2.5 clk = ~clk;

  function automatic logic [31:0] fuse_val(input logic [9:0] a);
    return (32'(a) * 32'h00010203) ^ 32'hA5C39E17;
  endfunction

  assign rd_b = ctrl_b[1] ? fuse_val(ctrl_b[15:6])[7:0] : 8'hEF;
  assign rd_w = ctrl_w[1] ? fuse_val(ctrl_w[25:16]) : 32'hDEADBEEF;

  fuse_read_seq #(.ADDR_LSB(6), .ADDR_W(10), .CAP_W(8), .ENTRY_MODE(1),
                  .PARK_MODE(1), .CLK_MHZ(3), .WAIT_US(2)) i_fuse_read_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_v[0]), .req_addr(req_addr),
    .req_count(req_count), .fuse_rdata(rd_b), .ctrl_word(ctrl_b),
    .busy(busy_b), .res_valid(rv_b), .res_data(data_b), .done(done_b));

  fuse_read_seq #(.ADDR_LSB(16), .ADDR_W(10), .CAP_W(32), .ENTRY_MODE(2),
                  .PARK_MODE(2), .CLK_MHZ(6), .WAIT_US(1)) i_fuse_read_seq_w (
    .clk(clk), .rst_n(rst_n), .req_valid(req_v[1]), .req_addr(req_addr),
    .req_count(req_count), .fuse_rdata(rd_w), .ctrl_word(ctrl_w),
    .busy(busy_w), .res_valid(rv_w), .res_data(data_w), .done(done_w));

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input int sel, input logic [31:0] ec, input logic eb, input logic erv,
                      input logic edone, input string tag);
    string t;
    @(negedge clk);
    kstep++;
    t = (poke_at != 0 && kstep > poke_at) ? "R7" : tag;
    if (sel == 0) begin
      chk(t, "ctrl", ctrl_b, ec); chk(t, "busy", 32'(busy_b), 32'(eb));
      chk(t, "res_valid", 32'(rv_b), 32'(erv)); chk(t, "res_data", 32'(data_b), exp_d[0]);
      chk(t, "done", 32'(done_b), 32'(edone)); chk(t, "other idle", 32'(busy_w), 32'd0);
    end else begin
      chk(t, "ctrl", ctrl_w, ec); chk(t, "busy", 32'(busy_w), 32'(eb));
      chk(t, "res_valid", 32'(rv_w), 32'(erv)); chk(t, "res_data", data_w, exp_d[1]);
      chk(t, "done", 32'(done_w), 32'(edone)); chk(t, "other idle", 32'(busy_b), 32'd0);
    end
    if (kstep == 1) req_v = 2'b00;
    if (poke_at != 0 && kstep == poke_at) begin
      req_v[poke_sel] = 1'b1; req_addr = 10'h2AA; req_count = 11'd4;
    end
    if (poke_at != 0 && kstep == poke_at + 1) req_v = 2'b00;
  endtask

  task automatic run(input int sel, input int a, input int n, input int poke);
    logic [31:0] ent, park, base;
    int lsb;
    ent = (sel == 0) ? ENT_B : ENT_W;
    park = (sel == 0) ? PARK_B : PARK_W;
    lsb = (sel == 0) ? 6 : 16;
    kstep = 0; poke_at = poke; poke_sel = sel;
    req_addr = 10'(a); req_count = 11'(n); req_v[sel] = 1'b1;
    if (n == 0) begin
      step(sel, park, 0, 0, 1, "R8");
      step(sel, park, 0, 0, 0, "R8");
      poke_at = 0;
      return;
    end
    if (sel == 0) step(sel, 32'h001, 1, 0, 0, "R2");
    repeat (W) step(sel, ent, 1, 0, 0, "R2");
    for (int i = 0; i < n; i++) begin
      logic [9:0] ad;
      ad = 10'(a + i);
      base = ent | (32'(ad) << lsb);
      repeat (W) step(sel, base, 1, 0, 0, "R3/R9");
      repeat (W) step(sel, base | 32'h2, 1, 0, 0, "R4");
      exp_d[sel] = (sel == 0) ? {24'h0, fuse_val(ad)[7:0]} : fuse_val(ad);
      step(sel, base, 1, 1, 0, "R5");
      repeat (W - 1) step(sel, base, 1, 0, 0, "R4");
    end
    step(sel, park, 0, 0, 1, "R6");
    step(sel, park, 0, 0, 0, "R6");
    poke_at = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    exp_d[0] = '0; exp_d[1] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "ctrl byte", ctrl_b, PARK_B);
    chk("R1", "ctrl word", ctrl_w, PARK_W);
    chk("R1", "busy", 32'({busy_b, busy_w}), 32'd0);
    chk("R1", "valid/done", 32'({rv_b, rv_w, done_b, done_w}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after release", ctrl_b, PARK_B);
    run(0, 5, 3, 0);
    run(1, 100, 2, 0);
    run(0, 1022, 3, 0);
    run(1, 1023, 2, 0);
    run(0, 9, 0, 0);
    run(1, 0, 0, 0);
    run(0, 7, 2, 5);
    run(1, 300, 2, 12);
    run(0, 0, 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule